// File: doc/BRIEF.md
# Write-Once Retrigger Watchdog Timer

This block is a watchdog timer with a single 32-bit control word on a simple register-write bus. The first write after reset fixes the whole configuration for the rest of the reset period and starts the count. That configuration is a reload count, a prescaler select, an enable and a two-bit signalling mode. From then on the written data is ignored. Each later write is a kick that reloads the down-counter from the stored reload count and restarts its timebase.

The count clock is derived as a clock enable at half the bus clock rate. With the prescaler selected, the count clock is further divided by a parameterised ratio. When the counter runs out, the block emits a one-cycle reset request pulse. In the interrupt mode it also raises an interrupt that stays high until reset, so software can begin an orderly restart. A read returns the stored configuration together with a locked flag.

Top module: `wdt_lockcfg`

## Requirements
- R1: After reset, rd_data reads 0, irq is 0 and rst_req is 0.
- R2: The first write stores reload = wr_data[11:0], prescale select = wr_data[12], enable = wr_data[13] and mode = wr_data[15:14]. From the next cycle, rd_data shows these in bits 15:0, bit 16 reads 1 (locked) and bits 31:17 read 0.
- R3: Once locked, a write of any data leaves rd_data unchanged.
- R4: With prescale select 0 and enable 1, reload value N gives a rst_req pulse in the cycle following the 2*(N+1)-th rising edge after the write edge. Before that cycle rst_req is 0. This holds for N from 0 to 4095.
- R5: With prescale select 1, the same interval becomes 2*PRESCALE_DIV*(N+1) edges.
- R6: A write after locking reloads the counter from the stored reload value and restarts the interval measured from that write's edge.
- R7: A write landing on the edge where expiry would occur wins. No rst_req or irq results from that edge, and a full new interval starts.
- R8: With enable 0 stored, no rst_req or irq ever occurs, whether or not kicks are written.
- R9: rst_req is high for exactly one cycle per expiry. irq rises at expiry only when mode is 2 and then stays 1 until reset; any other mode leaves irq 0.
- R10: After an expiry the block stays quiet until the next write, which arms a fresh interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Stored configuration in bits 15:0, locked flag in bit 16 |
| irq | output | 1 | Sticky expiry interrupt (mode 2 only) |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench aims a kick at exactly the expiry edge. A design that let expiry beat the write would emit a spurious reset request there. It sends kicks carrying all-ones data after locking, which a design without the write-once lock would take as a new configuration, changing the readback and the interval. The bench tests reload 0 and reload 4095, where an off-by-one in the half-rate enable or the terminal count moves the pulse by one or two cycles. It also checks the disabled and non-interrupt modes, where a leaky design would pulse or raise irq anyway.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int MODE_W   = 2;
   localparam logic [MODE_W-1:0] MODE_IRQ = 2'd2;

   typedef struct packed {
      logic [MODE_W-1:0] mode;
      logic              enable;
      logic              prescale;
   } wdt_ctl_t;
endpackage

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
   import wdt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int RELOAD_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   output logic                locked_o,
   output wdt_ctl_t            ctl_o,
   output logic [RELOAD_W-1:0] reload_o,
   output logic [RELOAD_W-1:0] load_val_o,
   output logic                load_en_o
);
   localparam int USED_W = RELOAD_W + 2 + MODE_W;

   logic                locked_q;
   wdt_ctl_t            ctl_q;
   logic [RELOAD_W-1:0] reload_q;
   wdt_ctl_t            ctl_in;

   assign ctl_in.prescale = wr_data[RELOAD_W];
   assign ctl_in.enable   = wr_data[RELOAD_W+1];
   assign ctl_in.mode     = wr_data[RELOAD_W+2 +: MODE_W];

   generate
      if (DATA_W > USED_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^wr_data[DATA_W-1:USED_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         ctl_q    <= '0;
         reload_q <= '0;
      end else if (wr_en && !locked_q) begin
         locked_q <= 1'b1;
         ctl_q    <= ctl_in;
         reload_q <= wr_data[RELOAD_W-1:0];
      end
   end

   assign locked_o   = locked_q;
   assign ctl_o      = ctl_q;
   assign reload_o   = reload_q;
   assign load_val_o = locked_q ? reload_q : wr_data[RELOAD_W-1:0];
   assign load_en_o  = locked_q ? ctl_q.enable : ctl_in.enable;

   assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> ($stable(ctl_q) && $stable(reload_q) && locked_q));
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int PRESCALE_DIV = 16384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic presc_sel,
   output logic tick_o
);
   logic cen_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) cen_q <= 1'b0;
      else                   cen_q <= ~cen_q;
   end

   generate
      if (PRESCALE_DIV == 1) begin : g_nopre
         logic unused_sel;
         assign unused_sel = presc_sel;
         assign tick_o = cen_q;
      end else begin : g_pre
         localparam int PW = $clog2(PRESCALE_DIV);
         localparam logic [PW-1:0] LAST = PW'(PRESCALE_DIV - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n || restart)   pre_q <= '0;
            else if (cen_q)          pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
         end
         assign tick_o = cen_q && (!presc_sel || pre_q == LAST);
      end
   endgenerate

   assert_tick_halfrate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int RELOAD_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [RELOAD_W-1:0] load_val,
   input  logic                load_en,
   input  logic                tick,
   input  logic                irq_mode,
   output logic                irq_o,
   output logic                rst_req_o
);
   logic [RELOAD_W-1:0] cnt_q;
   logic                armed_q;
   logic                fire;
   logic                irq_q;
   logic                req_q;

   assign fire = !load && armed_q && tick && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load) begin
         cnt_q   <= load_val;
         armed_q <= load_en;
      end else if (armed_q && tick) begin
         if (cnt_q == '0) armed_q <= 1'b0;
         else             cnt_q   <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         req_q <= fire;
         irq_q <= irq_q | (fire & irq_mode);
      end
   end

   assign irq_o     = irq_q;
   assign rst_req_o = req_q;

   assert_kick_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !rst_req_o);
   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);
   assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> irq_o);
   assert_quiet_disarmed_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !load) |=> !rst_req_o);
endmodule

// File: rtl/wdt_lockcfg.sv
module wdt_lockcfg
   import wdt_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int RELOAD_W     = 12,
   parameter int PRESCALE_DIV = 16384
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              rst_req
);
   localparam int RD_W = RELOAD_W + 3 + MODE_W;

   generate
      if (RD_W > DATA_W) begin : g_bad_width
         $error("wdt_lockcfg: DATA_W too small for fields");
      end
      if (PRESCALE_DIV < 1) begin : g_bad_div
         $error("wdt_lockcfg: PRESCALE_DIV must be at least 1");
      end
   endgenerate

   logic                locked;
   wdt_ctl_t            ctl;
   logic [RELOAD_W-1:0] reload;
   logic [RELOAD_W-1:0] load_val;
   logic                load_en;
   logic                tick;

   wdt_cfg_lock #(.DATA_W(DATA_W), .RELOAD_W(RELOAD_W)) u_lock (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .locked_o(locked), .ctl_o(ctl), .reload_o(reload),
      .load_val_o(load_val), .load_en_o(load_en)
   );

   wdt_tick_gen #(.PRESCALE_DIV(PRESCALE_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(wr_en),
      .presc_sel(ctl.prescale), .tick_o(tick)
   );

   wdt_down_counter #(.RELOAD_W(RELOAD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(wr_en), .load_val(load_val),
      .load_en(load_en), .tick(tick), .irq_mode(ctl.mode == MODE_IRQ),
      .irq_o(irq), .rst_req_o(rst_req)
   );

   assign rd_data = DATA_W'({locked, ctl, reload});

   assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !ctl.enable) |-> (!rst_req && !irq));
   assert_mode_gates_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && ctl.mode != MODE_IRQ) |-> !irq);
endmodule

// File: tb/wdt_lockcfg_bench.sv
module wdt_lockcfg_bench;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq, rst_req;
   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   wdt_lockcfg #(.DATA_W(32), .RELOAD_W(12), .PRESCALE_DIV(DIV)) u_wdt_lockcfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
   );

   function automatic int interval(input int n, input bit ps);
      return 2 * (ps ? DIV : 1) * (n + 1);
   endfunction

   function automatic logic [31:0] cfg_word(input int n, input bit ps, input bit en,
                                            input int mode, input logic [15:0] hi);
      return {hi, mode[1:0], en, ps, n[11:0]};
   endfunction

   function automatic logic [31:0] readback(input logic [31:0] w);
      return {15'd0, 1'b1, w[15:0]};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wait_edges(input int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic check_expire(input int n, input bit ps, input bit ib, input bit ia,
                               input string tag);
      int e = interval(n, ps);
      wait_edges(e - 1);
      check({tag, " before expiry rst_req"}, 32'(rst_req), 32'd0);
      check({tag, " before expiry irq"}, 32'(irq), 32'(ib));
      wait_edges(1);
      check({tag, " expiry rst_req"}, 32'(rst_req), 32'd1);
      check({tag, " expiry irq"}, 32'(irq), 32'(ia));
      wait_edges(1);
      check({tag, " pulse width R9"}, 32'(rst_req), 32'd0);
   endtask

   task automatic watch_quiet(input int k, input string tag);
      int seen = 0;
      for (int i = 0; i < k; i++) begin
         wait_edges(1);
         if (rst_req) seen++;
      end
      check({tag, " no rst_req pulses"}, 32'(seen), 32'd0);
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] w;
      void'($urandom(32'd20240611));

      // R1 reset state
      do_reset();
      check("R1 rd_data", rd_data, 32'd0);
      check("R1 irq", 32'(irq), 32'd0);
      check("R1 rst_req", 32'(rst_req), 32'd0);

      // R2 latch and readback, R4 timing, R10 quiet then rearm
      w = cfg_word(5, 1'b0, 1'b1, 2, 16'hA5C3);
      wr(w);
      check("R2 readback", rd_data, readback(w));
      check_expire(5, 1'b0, 1'b0, 1'b1, "R4 N=5");
      watch_quiet(40, "R10 after expiry");
      check("R9 irq sticky", 32'(irq), 32'd1);
      wr(32'h0);
      check_expire(5, 1'b0, 1'b1, 1'b1, "R10 rearm");

      // R9 non-irq mode, R3 lock, R6 reload from stored value
      do_reset();
      w = cfg_word(3, 1'b0, 1'b1, 1, 16'h0000);
      wr(w);
      check_expire(3, 1'b0, 1'b0, 1'b0, "R9 mode1");
      wr(32'hFFFF_FFFF);
      check("R3 readback after kick", rd_data, readback(w));
      check_expire(3, 1'b0, 1'b0, 1'b0, "R6 stored reload");

      // R6 kick mid-interval restarts
      do_reset();
      w = cfg_word(10, 1'b0, 1'b1, 2, 16'h1234);
      wr(w);
      wait_edges(10);
      wr(32'h0000_0FFF);
      check_expire(10, 1'b0, 1'b0, 1'b1, "R6 mid kick");

      // R7 kick on the expiry edge
      do_reset();
      w = cfg_word(4, 1'b0, 1'b1, 2, 16'h0);
      wr(w);
      wait_edges(interval(4, 1'b0) - 1);
      wr(32'hDEAD_BEEF);
      check("R7 rst_req on collide edge", 32'(rst_req), 32'd0);
      check("R7 irq on collide edge", 32'(irq), 32'd0);
      check_expire(4, 1'b0, 1'b0, 1'b1, "R7 after collide");

      // R8 disabled
      do_reset();
      w = cfg_word(0, 1'b0, 1'b0, 2, 16'h0);
      wr(w);
      watch_quiet(100, "R8 disabled");
      wr(32'h0000_2000);
      check("R8 readback unchanged", rd_data, readback(w));
      watch_quiet(100, "R8 disabled after kick");
      check("R8 irq", 32'(irq), 32'd0);

      // R5 prescaled
      do_reset();
      w = cfg_word(2, 1'b1, 1'b1, 2, 16'h0);
      wr(w);
      check_expire(2, 1'b1, 1'b0, 1'b1, "R5 N=2 prescaled");

      // R4 boundaries
      do_reset();
      wr(cfg_word(0, 1'b0, 1'b1, 2, 16'h0));
      check_expire(0, 1'b0, 1'b0, 1'b1, "R4 N=0");
      do_reset();
      wr(cfg_word(4095, 1'b0, 1'b1, 2, 16'h0));
      check_expire(4095, 1'b0, 1'b0, 1'b1, "R4 N=4095");

      // random configurations
      for (int it = 0; it < 8; it++) begin
         int n = int'($urandom_range(200, 0));
         bit ps = 1'($urandom_range(1, 0));
         int md = int'($urandom_range(3, 0));
         logic [15:0] hi = 16'($urandom);
         do_reset();
         w = cfg_word(n, ps, 1'b1, md, hi);
         wr(w);
         check("R2 random readback", rd_data, readback(w));
         check_expire(n, ps, 1'b0, md == 2, ps ? "R5 random" : "R4 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule